// File: doc/BRIEF.md
# Set/Clear Interrupt Controller Register Block

This block gathers interrupt requests from six peripheral sources and drives a single interrupt line towards a CPU. Each source delivers a one-cycle event pulse that latches a pending flag. Software enables sources through a mask. The CPU line is the registered OR of every pending flag whose mask bit is set.

Software reaches the block through a plain single-cycle word bus with an address, a write strobe, write data and combinational read data. There are four word registers. The mode register and the mask register are never loaded directly. Software changes them through pairs of set and clear bits, and a zero in either bit of a pair does nothing. The highest source has no dedicated clear input. Its pending flag is cleared by a command bit in the mode register. Sources 0 to 4 are cleared by their own clear pulses. The block also exposes a fixed 32-bit version word made of four 8-bit revision fields.

Top module: `irqc_top`

## Requirements
- R1: After reset, all stored bits are 0: the mode flags, the init length, the pending flags, the mask bits and `cpu_irq`.
- R2: A 1 on `src_evt[k]` for one cycle sets pending flag k. The pending register at byte offset 0x8 returns flag k in bit k (bits 5..0), and bits 31..6 read 0.
- R3: A 1 on `src_clr[k]` (k = 0..4) clears pending flag k. When an event and a clear arrive in the same cycle, the flag stays set.
- R4: A write to offset 0x0 with bit 11 set clears pending flag 5. An event on source 5 in the same cycle wins, and the flag stays set.
- R5: A write to the mask register at offset 0xC treats bits 11..0 as six pairs. For source k, bit 2k+1 sets mask bit k and bit 2k clears it. A 0 has no effect. When both bits of a pair are 1, the mask bit keeps its value.
- R6: A read at offset 0xC returns mask bit k in bit k (bits 5..0), and all other bits read 0.
- R7: On a write to offset 0x0, bits 13/12 set/clear flag A, bits 10/9 set/clear flag B, and bits 8/7 set/clear the init flag. A read returns A in bit 9, B in bit 8 and the init flag in bit 7. When both bits of a pair are 1, the flag holds its value.
- R8: Each write to offset 0x0 loads wdata bits 6..0 into the init length, which reads back in bits 6..0. Mode-register bits 31..10 read 0.
- R9: A read at offset 0x4 returns the `VERSION` parameter. Writes to offsets 0x4 and 0x8 change no state.
- R10: Offsets from 0x10 upward read 0, and writes to them change no register.
- R11: `cpu_irq` equals the OR of (pending AND mask) as it stood one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Byte address of the access (bits 1..0 ignored) |
| wr_en | input | 1 | Write strobe for this cycle |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| src_evt | input | 6 | One-cycle event pulse per source |
| src_clr | input | 5 | Clear pulse for sources 0 to 4 |
| cpu_irq | output | 1 | Registered interrupt request to the CPU |

## Verification
The pending flags hold the one real collision in this block: a source event can land in the same cycle as the clear of that same flag. For sources 0 to 4 the clear is the dedicated clear pulse. For source 5 it is a mode-register write with bit 11 set. The bench drives both in one cycle on source 0 and on source 5, then reads the pending register. It expects the flag still set, and it expects a lone clear afterwards to remove the flag. The interrupt line is judged in the same runs. It must stay low for one cycle after an unmasked flag rises, and stay high for one cycle after the flag is cleared.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int NSRC   = 6;
    localparam int DW     = 32;
    localparam int LEN_W  = 7;
    localparam int NFLAG  = 3;
    localparam int F_A    = 2;
    localparam int F_B    = 1;
    localparam int F_INIT = 0;

    typedef struct packed {
        logic [NFLAG-1:0] flags;
        logic [LEN_W-1:0] init_len;
    } mode_t;

    typedef struct packed {
        logic irq;
    } out_state_t;
endpackage

// File: rtl/irqc_pair_reg.sv
module irqc_pair_reg #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [N-1:0] set_bits,
    input  logic [N-1:0] clr_bits,
    output logic [N-1:0] q
);
    logic [N-1:0] bits_d, bits_q;

    always_comb begin
        bits_d = bits_q;
        if (we) begin
            for (int k = 0; k < N; k++) begin
                if (set_bits[k] && !clr_bits[k])
                    bits_d[k] = 1'b1;
                else if (clr_bits[k] && !set_bits[k])
                    bits_d[k] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_d;
    end

    assign q = bits_q;

    // Serves R5 (mask) and R7 (mode flags).
    for (genvar k = 0; k < N; k++) begin : g_chk
        a_r5_r7_set_only: assert property (@(posedge clk) disable iff (!rst_n)
            (we && set_bits[k] && !clr_bits[k]) |=> bits_q[k]);
        a_r5_r7_clr_only: assert property (@(posedge clk) disable iff (!rst_n)
            (we && clr_bits[k] && !set_bits[k]) |=> !bits_q[k]);
        a_r5_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!we || (set_bits[k] == clr_bits[k])) |=> bits_q[k] == $past(bits_q[k]));
    end
endmodule

// File: rtl/irqc_pending.sv
module irqc_pending #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);
    logic [N-1:0] pend_d, pend_q;

    always_comb begin
        pend_d = pend_q;
        for (int k = 0; k < N; k++) begin
            if (evt[k])      pend_d[k] = 1'b1;
            else if (clr[k]) pend_d[k] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend = pend_q;

    for (genvar k = 0; k < N; k++) begin : g_chk
        a_r2_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
            evt[k] |=> pend_q[k]);
        a_r3_clr_drops: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[k] && !evt[k]) |=> !pend_q[k]);
        a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr[k] && !evt[k]) |=> pend_q[k] == $past(pend_q[k]));
    end
endmodule

// File: rtl/irqc_mode.sv
module irqc_mode
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [NFLAG-1:0] set_bits,
    input  logic [NFLAG-1:0] clr_bits,
    input  logic [LEN_W-1:0] len_in,
    output mode_t            mode
);
    logic [NFLAG-1:0] flags;
    logic [LEN_W-1:0] len_d, len_q;

    irqc_pair_reg #(.N(NFLAG)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (we),
        .set_bits (set_bits),
        .clr_bits (clr_bits),
        .q        (flags)
    );

    always_comb begin
        len_d = len_q;
        if (we) len_d = len_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) len_q <= '0;
        else        len_q <= len_d;
    end

    assign mode.flags    = flags;
    assign mode.init_len = len_q;

    a_r8_len_load: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> len_q == $past(len_in));
    a_r8_len_keep: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(len_q));
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int          ADDR_W  = 6,
    parameter logic [31:0] VERSION = 32'h0302_0104
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    input  logic [NSRC-1:0]   src_evt,
    input  logic [NSRC-2:0]   src_clr,
    output logic              cpu_irq
);
    localparam int WORD_W = ADDR_W - 2;
    localparam logic [WORD_W-1:0] W_MODE = WORD_W'(0);
    localparam logic [WORD_W-1:0] W_VER  = WORD_W'(1);
    localparam logic [WORD_W-1:0] W_PEND = WORD_W'(2);
    localparam logic [WORD_W-1:0] W_MASK = WORD_W'(3);
    localparam int MODE_CLR5_BIT = 11;

    logic [WORD_W-1:0] word;
    logic              mode_we, mask_we;
    logic [NSRC-1:0]   pend, mask, pend_clr;
    logic [NSRC-1:0]   mset, mclr;
    logic [NFLAG-1:0]  fset, fclr;
    mode_t             mode;
    out_state_t        st_d, st_q;

    assign word    = addr[ADDR_W-1:2];
    assign mode_we = wr_en && (word == W_MODE);
    assign mask_we = wr_en && (word == W_MASK);

    for (genvar k = 0; k < NSRC; k++) begin : g_mpair
        assign mset[k] = wdata[2*k+1];
        assign mclr[k] = wdata[2*k];
    end

    assign fset = {wdata[13], wdata[10], wdata[8]};
    assign fclr = {wdata[12], wdata[9],  wdata[7]};
    assign pend_clr = {mode_we && wdata[MODE_CLR5_BIT], src_clr};

    irqc_pending #(.N(NSRC)) u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (src_evt),
        .clr   (pend_clr),
        .pend  (pend)
    );

    irqc_pair_reg #(.N(NSRC)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (mask_we),
        .set_bits (mset),
        .clr_bits (mclr),
        .q        (mask)
    );

    irqc_mode u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (mode_we),
        .set_bits (fset),
        .clr_bits (fclr),
        .len_in   (wdata[LEN_W-1:0]),
        .mode     (mode)
    );

    always_comb begin
        rdata = '0;
        case (word)
            W_MODE: rdata = {{(DW-LEN_W-NFLAG){1'b0}}, mode.flags, mode.init_len};
            W_VER:  rdata = VERSION;
            W_PEND: rdata = {{(DW-NSRC){1'b0}}, pend};
            W_MASK: rdata = {{(DW-NSRC){1'b0}}, mask};
            default: rdata = '0;
        endcase
    end

    always_comb begin
        st_d     = st_q;
        st_d.irq = |(pend & mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cpu_irq = st_q.irq;

    a_r11_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pend & mask)) |=> cpu_irq);
    a_r11_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(pend & mask)) |=> !cpu_irq);
    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (word > W_MASK) |-> rdata == '0);
    a_r9_version_read: assert property (@(posedge clk) disable iff (!rst_n)
        (word == W_VER) |-> rdata == VERSION);
    a_r10_mask_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_we |=> $stable(mask));
endmodule

// File: tb/tb_irqc_top.sv
module tb_irqc_top;
    localparam int          ADDR_W  = 6;
    localparam logic [31:0] VERSION = 32'h0302_0104;
    localparam int          NV      = 15;

    // {write addr, write data, read addr, expected read data}
    localparam logic [75:0] VEC [NV] = '{
        {6'h0C, 32'h0000_0AAA, 6'h0C, 32'h0000_003F},  // R5 set all, R6
        {6'h0C, 32'h0000_0001, 6'h0C, 32'h0000_003E},  // R5 clear src0
        {6'h0C, 32'h0000_0000, 6'h0C, 32'h0000_003E},  // R5 zeros
        {6'h0C, 32'h0000_0003, 6'h0C, 32'h0000_003E},  // R5 both ones hold 0
        {6'h0C, 32'h0000_000C, 6'h0C, 32'h0000_003E},  // R5 both ones hold 1
        {6'h0C, 32'h0000_0550, 6'h0C, 32'h0000_0002},  // R5 clear 5..2
        {6'h00, 32'h0000_2055, 6'h00, 32'h0000_0255},  // R7 A set, R8
        {6'h00, 32'h0000_047F, 6'h00, 32'h0000_037F},  // R7 B set
        {6'h00, 32'hFFFF_C100, 6'h00, 32'h0000_0380},  // R7 init set, R8 upper 0
        {6'h00, 32'h0000_1292, 6'h00, 32'h0000_0012},  // R7 clear all
        {6'h00, 32'h0000_3001, 6'h00, 32'h0000_0001},  // R7 both ones hold
        {6'h04, 32'hFFFF_FFFF, 6'h04, VERSION},        // R9 version
        {6'h08, 32'hFFFF_FFFF, 6'h08, 32'h0000_0000},  // R9 pending ignores write
        {6'h20, 32'h0000_2AAA, 6'h0C, 32'h0000_0002},  // R10 mask untouched
        {6'h30, 32'h0000_2FFF, 6'h00, 32'h0000_0001}   // R10 mode untouched
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic [ADDR_W-1:0] addr;
    logic              wr_en;
    logic [31:0]       wdata;
    logic [31:0]       rdata;
    logic [5:0]        src_evt;
    logic [4:0]        src_clr;
    logic              cpu_irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    irqc_top #(.ADDR_W(ADDR_W), .VERSION(VERSION)) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wr_en   (wr_en),
        .wdata   (wdata),
        .rdata   (rdata),
        .src_evt (src_evt),
        .src_clr (src_clr),
        .cpu_irq (cpu_irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic pulse(input logic [5:0] e, input logic [4:0] c);
        @(negedge clk);
        src_evt = e; src_clr = c;
        @(negedge clk);
        src_evt = '0; src_clr = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        rst_n = 1'b0; addr = '0; wr_en = 1'b0; wdata = '0; src_evt = '0; src_clr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(6'h00, d); check("R1 mode", d, 32'h0);
        rd(6'h08, d); check("R1 pending", d, 32'h0);
        rd(6'h0C, d); check("R1 mask", d, 32'h0);
        check("R1 irq", {31'b0, cpu_irq}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][75:70], VEC[i][69:38]);
            rd(VEC[i][37:32], d);
            check($sformatf("vec%0d R5-table", i), d, VEC[i][31:0]);
        end
        // mask = 0x02, mode = 0x001 now

        // R2 masked source: pending set, irq stays low (R11)
        pulse(6'h01, 5'h00);
        rd(6'h08, d); check("R2 pend src0", d, 32'h01);
        @(negedge clk);
        check("R11 masked stays low", {31'b0, cpu_irq}, 32'h0);

        // R11 one-cycle lag on rise
        pulse(6'h02, 5'h00);
        rd(6'h08, d); check("R2 pend src1", d, 32'h03);
        check("R11 lag before rise", {31'b0, cpu_irq}, 32'h0);
        @(negedge clk);
        check("R11 rise", {31'b0, cpu_irq}, 32'h1);

        // R3 clear and R11 lag on fall
        pulse(6'h00, 5'h02);
        rd(6'h08, d); check("R3 clear src1", d, 32'h01);
        check("R11 lag before fall", {31'b0, cpu_irq}, 32'h1);
        @(negedge clk);
        check("R11 fall", {31'b0, cpu_irq}, 32'h0);

        // R3 set wins over clear
        pulse(6'h01, 5'h01);
        rd(6'h08, d); check("R3 set wins", d, 32'h01);
        pulse(6'h00, 5'h01);
        rd(6'h08, d); check("R3 lone clear", d, 32'h00);

        // R4 source 5 cleared through mode bit 11
        pulse(6'h20, 5'h00);
        rd(6'h08, d); check("R2 pend src5", d, 32'h20);
        wr(6'h00, 32'h0000_0800);
        rd(6'h08, d); check("R4 mode clear src5", d, 32'h00);
        rd(6'h00, d); check("R8 len loaded 0", d, 32'h00);

        // R4 event on source 5 in the same cycle as the clear command
        @(negedge clk);
        addr = 6'h00; wdata = 32'h0000_0800; wr_en = 1'b1; src_evt = 6'h20;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0; src_evt = '0;
        rd(6'h08, d); check("R4 set wins", d, 32'h20);

        // R2 all sources at once, R3 clear lower five
        pulse(6'h3F, 5'h00);
        rd(6'h08, d); check("R2 all sources", d, 32'h3F);
        pulse(6'h00, 5'h1F);
        rd(6'h08, d); check("R3 clear 0..4", d, 32'h20);

        // R11 with source 5 unmasked, then R4 clear drops irq
        wr(6'h0C, 32'h0000_0800);
        @(negedge clk);
        check("R11 src5 irq", {31'b0, cpu_irq}, 32'h1);
        wr(6'h00, 32'h0000_0800);
        @(negedge clk);
        check("R4 R11 irq drops", {31'b0, cpu_irq}, 32'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule